// File: doc/BRIEF.md
# Boot ROM and Flash Bank Controller

This block sits between the system bus and the boot memory devices. Any address in the top 16 MB of the 32-bit space is boot memory. The upper 8 MB of that window maps to bank 0 and the lower 8 MB maps to bank 1. For each bank the block drives one active-high select. It also drives a shared output enable, a Flash write enable and a device address. A request is a single-cycle pulse that carries a read or write flag, an address and, for writes, data. The block answers every request it accepts with a one-cycle `done` pulse. For reads, the 64-bit result is on `rd_data` during that pulse.

Bank 1 is always a 64-bit device. Bank 0 is either a 64-bit device or an 8-bit device. A strap input decides which, and the block samples that strap only while reset is held. In 8-bit mode, a read of bank 0 becomes eight byte accesses to consecutive byte addresses. The block packs the eight bytes into one big-endian 64-bit word before it signals completion. Each device access holds its strobes for a wait-state count that is programmable per request.

Top module: `boot_rom_ctl`

## Requirements
- R1: An address from 0xFF80_0000 to 0xFFFF_FFFF selects bank 0. While that access runs, `rom_cs` is 2'b01, and at most one bit of `rom_cs` is ever high.
- R2: An address from 0xFF00_0000 to 0xFF7F_FFFF selects bank 1. While that access runs, `rom_cs` is 2'b10.
- R3: A request whose address lies below 0xFF00_0000 is ignored. No select or strobe rises, `busy` stays low and no `done` follows.
- R4: `cfg_narrow_strap` is sampled on every clock edge while `rst_n` is low. A 1 there makes bank 0 an 8-bit device and a 0 makes it a 64-bit device. Changes to the strap after reset have no effect.
- R5: Bank 1 accesses are always single 64-bit accesses, whatever the strap value.
- R6: In 64-bit mode, `rom_addr[19:0]` is address bits 22:3 and `rom_addr[20]` is 0. In 8-bit mode, `rom_addr` is the byte address, bits 20:0. Beat i of a read uses the request address with bits 2:0 replaced by i, for i = 0 to 7.
- R7: In 8-bit mode each byte is taken from `rom_din[7:0]`. The byte from beat 0 (lowest address) lands in `rd_data[63:56]`, and the byte from beat 7 lands in `rd_data[7:0]`.
- R8: Each device access keeps its select, and its output enable (reads) or write enable (writes), high for `cfg_wait`+1 cycles. The `cfg_wait` value is captured when the request is accepted.
- R9: During a write, `rom_we` is high and `rom_oe` is low, for one access only. In 8-bit mode the write carries one byte: `rom_dout` is `req_wdata[7:0]` zero-extended, at the exact byte address. Otherwise `rom_dout` is `req_wdata`.
- R10: `done` is high for exactly one cycle, in the cycle after the last access ends. That is N*(`cfg_wait`+1) cycles after the accepting edge, where N is 8 for 8-bit reads and 1 otherwise. All selects are low in that cycle.
- R11: A request is accepted only while `busy` is low. Requests arriving while busy are dropped.
- R12: During reset and directly after it, `busy`, `done`, `rom_cs`, `rom_oe` and `rom_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| cfg_narrow_strap | input | 1 | Bank 0 width strap (1 = 8-bit) |
| cfg_wait | input | 4 | Wait states per device access |
| req_valid | input | 1 | Request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | System byte address |
| req_wdata | input | 64 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 64 | Read result, valid with `done` |
| rom_cs | output | 2 | Bank selects, bit 0 = bank 0 |
| rom_oe | output | 1 | Shared output enable |
| rom_we | output | 1 | Flash write enable |
| rom_addr | output | 21 | Device address |
| rom_din | input | 64 | Data from the devices |
| rom_dout | output | 64 | Data to the devices |

## Verification
A request is accepted on the rising edge where it is sampled. From the next cycle on, beat i of the access occupies cycles i*(W+1) through i*(W+1)+W after that edge, and `done` falls in cycle N*(W+1). The bench drives inputs at falling edges. It counts falling edges from the accepting edge and compares the selects, strobes and address at each one against the beat that index belongs to. It checks `done` and `rd_data` at exactly index N*(W+1), and checks for idle one cycle later. To prove that the wait count is captured at accept time, the bench changes `cfg_wait` right after the accepting edge.

// File: rtl/boot_rom_ctl_pkg.sv
package boot_rom_ctl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BEAT = 2'd1,
      ST_DONE = 2'd2
   } rom_st_e;

   localparam int unsigned NUM_BANKS = 2;
   localparam int unsigned LANE_W    = 8;
endpackage

// File: rtl/boot_rom_decode.sv
module boot_rom_decode #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BANK_LOG2 = 23
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              bank_sel
);
   // The window is the top two banks: every bit above the bank-select bit is set.
   assign hit      = &addr[ADDR_W-1:BANK_LOG2+1];
   // Upper half of the window is bank 0, lower half is bank 1.
   assign bank_sel = ~addr[BANK_LOG2];
endmodule

// File: rtl/boot_rom_seq.sv
module boot_rom_seq
   import boot_rom_ctl_pkg::*;
#(
   parameter int unsigned ROM_AW    = 21,
   parameter int unsigned LANE_LOG2 = 3,
   parameter int unsigned WAIT_W    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  start_write,
   input  logic                  start_bank,
   input  logic                  start_narrow,
   input  logic [ROM_AW-1:0]     start_addr,
   input  logic [WAIT_W-1:0]     wait_cfg,
   output logic                  busy,
   output logic                  done,
   output logic [NUM_BANKS-1:0]  rom_cs,
   output logic                  rom_oe,
   output logic                  rom_we,
   output logic [ROM_AW-1:0]     rom_addr,
   output logic                  cap,
   output logic                  cap_narrow,
   output logic [LANE_LOG2-1:0]  cap_beat
);
   rom_st_e               st;
   logic [WAIT_W-1:0]     cnt;
   logic [WAIT_W-1:0]     wait_q;
   logic [LANE_LOG2-1:0]  beat;
   logic                  bank_q;
   logic                  wr_q;
   logic                  nar_q;
   logic [ROM_AW-1:0]     addr_q;
   logic                  in_beat;
   logic                  beat_end;
   logic                  last_beat;

   assign in_beat   = (st == ST_BEAT);
   assign beat_end  = in_beat && (cnt == '0);
   assign last_beat = !nar_q || wr_q || (&beat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         wait_q <= '0;
         beat   <= '0;
         bank_q <= 1'b0;
         wr_q   <= 1'b0;
         nar_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_BEAT;
                  cnt    <= wait_cfg;
                  wait_q <= wait_cfg;
                  beat   <= '0;
                  bank_q <= start_bank;
                  wr_q   <= start_write;
                  nar_q  <= start_narrow;
                  addr_q <= start_addr;
               end
            end
            ST_BEAT: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (last_beat) begin
                  st <= ST_DONE;
               end else begin
                  beat                     <= beat + 1'b1;
                  cnt                      <= wait_q;
                  addr_q[LANE_LOG2-1:0]    <= beat + 1'b1;
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
      localparam logic BANK_ID = (b != 0);
      assign rom_cs[b] = in_beat && (bank_q == BANK_ID);
   end

   assign busy       = (st != ST_IDLE);
   assign done       = (st == ST_DONE);
   assign rom_oe     = in_beat && !wr_q;
   assign rom_we     = in_beat && wr_q;
   assign rom_addr   = addr_q;
   assign cap        = beat_end && !wr_q;
   assign cap_narrow = nar_q;
   assign cap_beat   = beat;
endmodule

// File: rtl/boot_rom_gather.sv
module boot_rom_gather
   import boot_rom_ctl_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned LANE_LOG2 = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap,
   input  logic                  cap_narrow,
   input  logic [LANE_LOG2-1:0]  cap_beat,
   input  logic [DATA_W-1:0]     din,
   output logic [DATA_W-1:0]     dout
);
   localparam int unsigned LANES = DATA_W / LANE_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      // Beat 0 (lowest byte address) fills the most significant lane.
      localparam int unsigned SLOT = LANES - 1 - g;
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (cap) begin
            if (!cap_narrow)
               lane_q <= din[g*LANE_W +: LANE_W];
            else if (cap_beat == SLOT[LANE_LOG2-1:0])
               lane_q <= din[LANE_W-1:0];
         end
      end
      assign dout[g*LANE_W +: LANE_W] = lane_q;
   end
endmodule

// File: rtl/boot_rom_ctl.sv
module boot_rom_ctl
   import boot_rom_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned BANK_LOG2 = 23,
   parameter int unsigned NARROW_AW = 21,
   parameter int unsigned WAIT_W    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_narrow_strap,
   input  logic [WAIT_W-1:0]     cfg_wait,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  busy,
   output logic                  done,
   output logic [DATA_W-1:0]     rd_data,
   output logic [1:0]            rom_cs,
   output logic                  rom_oe,
   output logic                  rom_we,
   output logic [NARROW_AW-1:0]  rom_addr,
   input  logic [DATA_W-1:0]     rom_din,
   output logic [DATA_W-1:0]     rom_dout
);
   localparam int unsigned LANES     = DATA_W / LANE_W;
   localparam int unsigned LANE_LOG2 = $clog2(LANES);
   localparam int unsigned WIDE_AW   = BANK_LOG2 - LANE_LOG2;
   localparam int unsigned ROM_AW    = NARROW_AW;

   if (DATA_W % LANE_W != 0 || (1 << LANE_LOG2) != LANES || LANES < 2) begin : g_bad_data_w
      $error("DATA_W must be a power-of-two multiple of the byte lane, at least two lanes");
   end
   if (NARROW_AW < WIDE_AW || NARROW_AW > BANK_LOG2 || NARROW_AW <= LANE_LOG2) begin : g_bad_aw
      $error("NARROW_AW must cover the wide address and fit inside one bank");
   end
   if (ADDR_W <= BANK_LOG2 + 1) begin : g_bad_addr_w
      $error("ADDR_W too small for the two-bank window");
   end

   logic                  narrow_mode_q;
   logic                  hit;
   logic                  bank_sel;
   logic                  start;
   logic                  start_narrow;
   logic [ROM_AW-1:0]     start_addr;
   logic [DATA_W-1:0]     wdata_q;
   logic                  cap;
   logic                  cap_narrow;
   logic [LANE_LOG2-1:0]  cap_beat;

   // Strap capture: follows the pin only while reset is held.
   always_ff @(posedge clk) begin
      if (!rst_n) narrow_mode_q <= cfg_narrow_strap;
   end

   boot_rom_decode #(
      .ADDR_W    (ADDR_W),
      .BANK_LOG2 (BANK_LOG2)
   ) u_decode (
      .addr     (req_addr),
      .hit      (hit),
      .bank_sel (bank_sel)
   );

   assign start        = req_valid && hit && !busy;
   assign start_narrow = narrow_mode_q && !bank_sel;

   always_comb begin
      if (start_narrow) begin
         if (req_write)
            start_addr = req_addr[ROM_AW-1:0];
         else
            start_addr = {req_addr[ROM_AW-1:LANE_LOG2], {LANE_LOG2{1'b0}}};
      end else begin
         start_addr = ROM_AW'(req_addr[BANK_LOG2-1:LANE_LOG2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wdata_q <= '0;
      else if (start)
         wdata_q <= start_narrow ? DATA_W'(req_wdata[LANE_W-1:0]) : req_wdata;
   end
   assign rom_dout = wdata_q;

   boot_rom_seq #(
      .ROM_AW    (ROM_AW),
      .LANE_LOG2 (LANE_LOG2),
      .WAIT_W    (WAIT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_write  (req_write),
      .start_bank   (bank_sel),
      .start_narrow (start_narrow),
      .start_addr   (start_addr),
      .wait_cfg     (cfg_wait),
      .busy         (busy),
      .done         (done),
      .rom_cs       (rom_cs),
      .rom_oe       (rom_oe),
      .rom_we       (rom_we),
      .rom_addr     (rom_addr),
      .cap          (cap),
      .cap_narrow   (cap_narrow),
      .cap_beat     (cap_beat)
   );

   boot_rom_gather #(
      .DATA_W    (DATA_W),
      .LANE_LOG2 (LANE_LOG2)
   ) u_gather (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap        (cap),
      .cap_narrow (cap_narrow),
      .cap_beat   (cap_beat),
      .din        (rom_din),
      .dout       (rd_data)
   );
endmodule

// File: rtl/boot_rom_ctl_chk.sv
module boot_rom_ctl_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned ROM_AW = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              busy,
   input logic              done,
   input logic [1:0]        rom_cs,
   input logic              rom_oe,
   input logic              rom_we,
   input logic [ROM_AW-1:0] rom_addr
);
   p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rom_cs));

   p_outside_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && !(&req_addr[ADDR_W-1:ADDR_W-8])) |=> !busy);

   p_no_spurious_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> !busy);

   p_bank1_wide_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cs[1] |-> !rom_addr[ROM_AW-1]);

   p_strobe_has_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_oe || rom_we) |-> (rom_cs != 2'b00));

   p_oe_we_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_oe && rom_we));

   p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rom_cs == 2'b00 && !rom_oe && !rom_we));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(rom_cs) != 2'b00));
endmodule

bind boot_rom_ctl boot_rom_ctl_chk #(
   .ADDR_W (ADDR_W),
   .ROM_AW (NARROW_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .busy      (busy),
   .done      (done),
   .rom_cs    (rom_cs),
   .rom_oe    (rom_oe),
   .rom_we    (rom_we),
   .rom_addr  (rom_addr)
);

// File: tb/boot_rom_ctl_test.sv
module boot_rom_ctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_narrow_strap = 1'b0;
   logic [3:0]  cfg_wait = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        busy, done;
   logic [63:0] rd_data;
   logic [1:0]  rom_cs;
   logic        rom_oe, rom_we;
   logic [20:0] rom_addr;
   logic [63:0] rom_din;
   logic [63:0] rom_dout;

   int checks = 0;
   int failures = 0;
   bit model_narrow = 1'b0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   boot_rom_ctl uut (
      .clk(clk), .rst_n(rst_n), .cfg_narrow_strap(cfg_narrow_strap),
      .cfg_wait(cfg_wait), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .rd_data(rd_data), .rom_cs(rom_cs), .rom_oe(rom_oe), .rom_we(rom_we),
      .rom_addr(rom_addr), .rom_din(rom_din), .rom_dout(rom_dout)
   );

   function automatic logic [7:0] byte_f(input logic [20:0] a);
      return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h3C;
   endfunction

   function automatic logic [63:0] word_f(input logic bank, input logic [20:0] a);
      return {a[15:0] ^ 16'h1111, a[15:0] ^ 16'h2222, {11'b0, a[20:16]}, 16'hBEEF ^ {15'b0, bank}};
   endfunction

   // Device model: bank 0 answers as a byte device in narrow mode.
   always_comb begin
      if (rom_cs[0] && model_narrow) rom_din = {56'b0, byte_f(rom_addr)};
      else if (rom_cs[0])            rom_din = word_f(1'b0, rom_addr);
      else if (rom_cs[1])            rom_din = word_f(1'b1, rom_addr);
      else                           rom_din = '0;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input bit strap);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_narrow_strap = strap;
      model_narrow = strap;
      repeat (3) @(negedge clk);
      chk({busy, done, rom_cs, rom_oe, rom_we} == 6'b0, "R12", "in reset",
          64'({busy, done, rom_cs, rom_oe, rom_we}), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, rom_cs, rom_oe, rom_we} == 6'b0, "R12", "after reset",
          64'({busy, done, rom_cs, rom_oe, rom_we}), 64'h0);
   endtask

   // Generic access: counts falling edges after the accepting edge.
   task automatic do_access(input logic wr, input logic [31:0] a, input logic [63:0] wd,
                            input int w, input string req);
      bit nar = model_narrow && a[23];
      int beats = (nar && !wr) ? 8 : 1;
      int total = beats * (w + 1);
      logic [1:0] exp_cs = a[23] ? 2'b01 : 2'b10;
      logic [63:0] exp_rd = '0;
      logic [63:0] exp_wd = nar ? {56'b0, wd[7:0]} : wd;
      bit ok_strobe = 1'b1, ok_addr = 1'b1, ok_wd = 1'b1;
      logic [63:0] bad_act = '0, bad_exp = '0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; cfg_wait = 4'(w);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cfg_wait = 4'((w + 5) % 16);   // must not matter after accept (R8)
      for (int k = 0; k < total; k++) begin
         int bt = k / (w + 1);
         logic [20:0] ea;
         if (nar && wr)      ea = a[20:0];
         else if (nar)       ea = {a[20:3], 3'(bt)};
         else                ea = {1'b0, a[22:3]};
         if (!(busy && !done && rom_cs == exp_cs && rom_oe == !wr && rom_we == wr)) begin
            if (ok_strobe) begin bad_act = 64'({busy, done, rom_cs, rom_oe, rom_we});
               bad_exp = 64'({2'b10, exp_cs, !wr, wr}); end
            ok_strobe = 1'b0;
         end
         if (rom_addr != ea) ok_addr = 1'b0;
         if (wr && rom_dout != exp_wd) ok_wd = 1'b0;
         @(negedge clk);
      end
      chk(ok_strobe, req, "R8 strobes held W+1 cycles per beat", bad_act, bad_exp);
      chk(ok_addr, req, "R6 device address sequence", 64'(rom_addr), 64'h0);
      if (wr) chk(ok_wd, req, "R9 write data", rom_dout, exp_wd);
      chk(done && rom_cs == 2'b00 && !rom_oe && !rom_we, req, "R10 done timing",
          64'({done, rom_cs, rom_oe, rom_we}), 64'h10);
      if (!wr) begin
         if (nar) for (int i = 0; i < 8; i++) exp_rd[63-8*i -: 8] = byte_f({a[20:3], 3'(i)});
         else     exp_rd = word_f(!a[23], {1'b0, a[22:3]});
         chk(rd_data == exp_rd, req, "R7 read result", rd_data, exp_rd);
      end
      @(negedge clk);
      chk(!done && !busy, req, "R10 single done pulse", 64'({done, busy}), 64'h0);
   endtask

   task automatic t_ignored(input logic [31:0] a);
      bit ok = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; cfg_wait = 4'd0;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         if (busy || done || rom_cs != 2'b00 || rom_oe || rom_we) ok = 1'b0;
         @(negedge clk);
      end
      chk(ok, "R3", "out-of-window request ignored", 64'(a), 64'h0);
   endtask

   task automatic t_busy_drop();
      bit ok = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hFFFF_FF00; cfg_wait = 4'd4;
      @(posedge clk);
      @(negedge clk);
      req_addr = 32'hFF00_0000;   // competing request while busy
      for (int k = 0; k < 5; k++) begin
         if (k == 2) req_valid = 1'b0;
         if (rom_cs != 2'b01 || done) ok = 1'b0;
         @(negedge clk);
      end
      chk(ok, "R11", "busy request did not change access", 64'(rom_cs), 64'h1);
      chk(done, "R11", "original access completes", 64'(done), 64'h1);
      @(negedge clk);
      chk(!busy && rom_cs == 2'b00, "R11", "dropped request not started later",
          64'({busy, rom_cs}), 64'h0);
   endtask

   initial begin
      // Narrow strap phase
      do_reset(1'b1);
      do_access(1'b0, 32'hFFC0_1238, 64'h0, 0, "R6");
      do_access(1'b0, 32'hFF80_0000, 64'h0, 2, "R1");
      do_access(1'b1, 32'hFFFF_FFFF, 64'hDEAD_BEEF_0123_45A7, 1, "R9");
      do_access(1'b0, 32'hFF7F_FFF8, 64'h0, 3, "R5");
      do_access(1'b1, 32'hFF00_0000, 64'h0F1E_2D3C_4B5A_6978, 0, "R2");
      t_ignored(32'hFEFF_FFF8);
      t_ignored(32'h0000_0000);
      cfg_narrow_strap = 1'b0;   // after reset: no effect (R4)
      do_access(1'b0, 32'hFFAB_CDE0, 64'h0, 1, "R4");
      // Wide strap phase
      do_reset(1'b0);
      do_access(1'b0, 32'hFFFF_FFF8, 64'h0, 5, "R4");
      do_access(1'b1, 32'hFF90_0010, 64'h1122_3344_5566_7788, 2, "R9");
      do_access(1'b0, 32'hFF12_3450, 64'h0, 15, "R8");
      t_busy_drop();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule